// File: doc/BRIEF.md
# Virtual Processor Run Controller

This block keeps the run or halt state of several virtual processors (VPs) that share one core, and holds for each VP the address that VP fetches from when it comes out of reset. Software talks to it through a simple register bus. Each request carries the index of the VP that issues it. The block drives three things for each VP: a run enable, a one-cycle reset pulse, and the reset base address.

Bringing a halted VP into the run state always restarts it. The VP receives a reset pulse in the same cycle that its run enable rises, so it starts at its programmed base rather than resuming where it stopped. Each VP has its own base register, which it reaches through a local window. Each VP also has its own peer selector. A second window uses that selector to route the access to another VP's base register, so one VP can set the start address of another before it launches it.

A build parameter picks the state after system reset: either only VP 0 runs, or all VPs run.

Top module: `vp_run_ctrl`

## Requirements
- R1: After reset, with `START_VP0_ONLY`=1, only VP 0 runs (`vp_run` = 1 at bit 0 only), `vp_rst_pulse` is zero, and every VP's base equals `DEF_BASE` (default 0x0000_1000).
- R2: A write to offset 0x00 (the launch register) sets the run state of every VP whose mask bit `wdata[i]` is 1. The new state is visible in the cycle after the write. VPs whose mask bit is 0 keep their state.
- R3: A write to offset 0x04 (the halt register) clears the run state of every VP whose mask bit is 1. The change is visible in the cycle after the write.
- R4: When a VP goes from halted to running, `vp_rst_pulse[i]` is 1 for exactly the cycle in which `vp_run[i]` first reads 1.
- R5: A launch bit for a VP that is already running changes nothing and produces no reset pulse.
- R6: A read returns its data on `bus_rdata`, with `bus_rvalid` high, in the cycle after the request. Offset 0x08 returns the run state, with bit i set for each running VP.
- R7: Reads of the launch register (0x00), the halt register (0x04) and any unmapped offset return zero.
- R8: Offset 0x10 is the requester's own base register. A write stores `wdata` with the low `ALIGN_BITS` (default 12) forced to zero. A read returns the stored value. The stored base drives `vp_base[i*32 +: 32]`.
- R9: Offset 0x0C is the requester's own peer selector, holding a VP index. Offset 0x20 reads and writes the base register of the VP named by the requester's selector, with the same alignment as R8. The selector of each VP resets to zero.
- R10: Writes to a base register or a selector leave `vp_run` unchanged and produce no reset pulse. A base written before a launch is the base presented with that launch's pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_src | input | SEL_W | Index of the VP issuing the access |
| bus_rdata | output | DATA_W | Read data, valid when bus_rvalid is 1 |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| vp_run | output | NUM_VP | Run enable for each VP |
| vp_rst_pulse | output | NUM_VP | One-cycle reset pulse for each VP |
| vp_base | output | NUM_VP*DATA_W | Reset base address for each VP, VP i at bits i*DATA_W +: DATA_W |

## Verification
The bench launches VPs that are already running, to confirm that no second reset pulse appears. A design that pulsed on every launch bit would restart running VPs without cause. It also checks that the pulse lasts one cycle and lines up with the rising run enable. A pulse that was too long or out of step would reset a VP twice, or reset it before it was enabled.

The peer window is exercised with different requesters, to confirm that the selector belongs to each VP. It also confirms that a write through the window changes only the target's base. A design that shared one selector or wrote the requester's own base would break cross-VP setup. A final relaunch shows the new base on the output together with the pulse. The bench also checks that launch, halt and unmapped offsets read as zero, and that misaligned base data comes back with its low bits cleared.

// File: rtl/vprc_pkg.sv
package vprc_pkg;

  // register select produced by the address decoder
  typedef enum logic [2:0] {
    RS_NONE,
    RS_LAUNCH,
    RS_HALT,
    RS_STATUS,
    RS_PEERIDX,
    RS_LOCAL,
    RS_PEER
  } regsel_e;

  // byte offsets of the register window
  localparam int unsigned OFS_LAUNCH  = 'h00;
  localparam int unsigned OFS_HALT    = 'h04;
  localparam int unsigned OFS_STATUS  = 'h08;
  localparam int unsigned OFS_PEERIDX = 'h0C;
  localparam int unsigned OFS_LOCAL   = 'h10;
  localparam int unsigned OFS_PEER    = 'h20;

endpackage

// File: rtl/vprc_decode.sv
module vprc_decode
  import vprc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output regsel_e           sel
);

  always_comb begin
    if (addr == ADDR_W'(OFS_LAUNCH))       sel = RS_LAUNCH;
    else if (addr == ADDR_W'(OFS_HALT))    sel = RS_HALT;
    else if (addr == ADDR_W'(OFS_STATUS))  sel = RS_STATUS;
    else if (addr == ADDR_W'(OFS_PEERIDX)) sel = RS_PEERIDX;
    else if (addr == ADDR_W'(OFS_LOCAL))   sel = RS_LOCAL;
    else if (addr == ADDR_W'(OFS_PEER))    sel = RS_PEER;
    else                                   sel = RS_NONE;
  end

endmodule

// File: rtl/vprc_runstate.sv
module vprc_runstate #(
  parameter int unsigned NUM_VP         = 4,
  parameter bit          START_VP0_ONLY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_stb,
  input  logic              halt_stb,
  input  logic [NUM_VP-1:0] mask,
  output logic [NUM_VP-1:0] run_q,
  output logic [NUM_VP-1:0] pulse_q
);

  localparam logic [NUM_VP-1:0] RUN_INIT =
    START_VP0_ONLY ? NUM_VP'(1) : {NUM_VP{1'b1}};

  logic [NUM_VP-1:0] set_m, clr_m, run_nxt, pulse_nxt;
  logic              upd_en;

  always_comb begin
    set_m     = launch_stb ? mask : '0;
    clr_m     = halt_stb   ? mask : '0;
    // halt wins over launch for the same VP
    run_nxt   = (run_q | set_m) & ~clr_m;
    pulse_nxt = run_nxt & ~run_q;
    upd_en    = launch_stb | halt_stb | (|pulse_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= RUN_INIT;
      pulse_q <= '0;
    end else if (upd_en) begin
      run_q   <= run_nxt;
      pulse_q <= pulse_nxt;
    end
  end

  for (genvar i = 0; i < NUM_VP; i++) begin : g_chk
    // R4: a rising run enable comes with its reset pulse
    p_pulse_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q[i]) |-> pulse_q[i]);
    // R4: the pulse lasts a single cycle
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q[i] |=> !pulse_q[i]);
    // R2: running starts only after a launch command for that VP
    p_rise_needs_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q[i]) |-> $past(launch_stb && mask[i]));
    // R3: halt command stops the VP
    p_halt_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_stb && mask[i]) |=> !run_q[i]);
    // R5: launching a running VP yields no pulse
    p_no_repulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[i] && !halt_stb) |=> !pulse_q[i]);
  end

endmodule

// File: rtl/vprc_bases.sv
module vprc_bases #(
  parameter int unsigned NUM_VP     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned ALIGN_BITS = 12,
  parameter logic [DATA_W-1:0] DEF_BASE = 32'h0000_1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SEL_W-1:0]         src,
  input  logic                     wr_local,
  input  logic                     wr_peer,
  input  logic                     wr_idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [NUM_VP*DATA_W-1:0] base_flat,
  output logic [DATA_W-1:0]        own_base,
  output logic [DATA_W-1:0]        peer_base,
  output logic [SEL_W-1:0]         own_idx
);

  localparam logic [DATA_W-1:0] ALIGN_MASK = ~((DATA_W'(1) << ALIGN_BITS) - DATA_W'(1));

  logic [DATA_W-1:0] base_q [NUM_VP];
  logic [SEL_W-1:0]  idx_q  [NUM_VP];
  logic [SEL_W-1:0]  tgt;
  logic [NUM_VP-1:0] base_we, idx_we;

  always_comb begin
    own_idx   = '0;
    own_base  = '0;
    for (int k = 0; k < NUM_VP; k++) begin
      if (src == SEL_W'(k)) begin
        own_idx  = idx_q[k];
        own_base = base_q[k];
      end
    end
    tgt       = own_idx;
    peer_base = '0;
    for (int k = 0; k < NUM_VP; k++) begin
      if (tgt == SEL_W'(k)) peer_base = base_q[k];
    end
  end

  for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
    logic [DATA_W-1:0] base_nxt;
    logic [SEL_W-1:0]  idx_nxt;

    always_comb begin
      base_we[i] = (wr_local && src == SEL_W'(i)) || (wr_peer && tgt == SEL_W'(i));
      idx_we[i]  = wr_idx && src == SEL_W'(i);
      base_nxt   = wdata & ALIGN_MASK;
      idx_nxt    = wdata[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          base_q[i] <= DEF_BASE & ALIGN_MASK;
      else if (base_we[i]) base_q[i] <= base_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         idx_q[i] <= '0;
      else if (idx_we[i]) idx_q[i] <= idx_nxt;
    end

    assign base_flat[i*DATA_W +: DATA_W] = base_q[i];

    // R10: a base only changes on a write aimed at it
    p_base_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !base_we[i] |=> $stable(base_q[i]));
    // R8: a base written through either window is stored aligned
    p_base_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      base_we[i] |=> (base_q[i] == ($past(wdata) & ALIGN_MASK)));
  end

endmodule

// File: rtl/vp_run_ctrl.sv
module vp_run_ctrl
  import vprc_pkg::*;
#(
  parameter int unsigned NUM_VP         = 4,
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned ALIGN_BITS     = 12,
  parameter bit          START_VP0_ONLY = 1'b1,
  parameter logic [DATA_W-1:0] DEF_BASE = 32'h0000_1000,
  parameter int unsigned SEL_W          = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_req,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [SEL_W-1:0]         bus_src,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  output logic [NUM_VP-1:0]        vp_run,
  output logic [NUM_VP-1:0]        vp_rst_pulse,
  output logic [NUM_VP*DATA_W-1:0] vp_base
);

  regsel_e           sel;
  logic              wr, rd;
  logic [DATA_W-1:0] own_base, peer_base, rdata_nxt, rdata_q;
  logic [SEL_W-1:0]  own_idx;
  logic              rvalid_q;

  vprc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  always_comb begin
    wr = bus_req &&  bus_we;
    rd = bus_req && !bus_we;
  end

  vprc_runstate #(
    .NUM_VP         (NUM_VP),
    .START_VP0_ONLY (START_VP0_ONLY)
  ) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_stb (wr && sel == RS_LAUNCH),
    .halt_stb   (wr && sel == RS_HALT),
    .mask       (bus_wdata[NUM_VP-1:0]),
    .run_q      (vp_run),
    .pulse_q    (vp_rst_pulse)
  );

  vprc_bases #(
    .NUM_VP     (NUM_VP),
    .DATA_W     (DATA_W),
    .SEL_W      (SEL_W),
    .ALIGN_BITS (ALIGN_BITS),
    .DEF_BASE   (DEF_BASE)
  ) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (bus_src),
    .wr_local  (wr && sel == RS_LOCAL),
    .wr_peer   (wr && sel == RS_PEER),
    .wr_idx    (wr && sel == RS_PEERIDX),
    .wdata     (bus_wdata),
    .base_flat (vp_base),
    .own_base  (own_base),
    .peer_base (peer_base),
    .own_idx   (own_idx)
  );

  // read multiplexer; write-only and unmapped offsets return zero
  always_comb begin
    unique case (sel)
      RS_STATUS:  rdata_nxt = DATA_W'(vp_run);
      RS_PEERIDX: rdata_nxt = DATA_W'(own_idx);
      RS_LOCAL:   rdata_nxt = own_base;
      RS_PEER:    rdata_nxt = peer_base;
      default:    rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd) rdata_q <= rdata_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rd;
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R6: every read is answered in the following cycle, and only reads are
  p_rvalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
  p_rvalid_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !bus_rvalid);
  // R7: launch and halt offsets read back as zero
  p_wo_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (sel == RS_LAUNCH || sel == RS_HALT)) |=> (bus_rdata == '0));
  // R10: base and selector writes do not touch the run state
  p_cfg_no_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel == RS_LOCAL || sel == RS_PEER || sel == RS_PEERIDX)) |=> $stable(vp_run));

endmodule

// File: tb/tb_vp_run_ctrl.sv
`timescale 1ns/1ps
module tb_vp_run_ctrl;

  localparam int NV = 4;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int SW = 2;
  localparam logic [31:0] DEF = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [SW-1:0] bus_src;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [NV-1:0] vp_run, vp_rst_pulse;
  logic [NV*DW-1:0] vp_base;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  vp_run_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_src(bus_src),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .vp_run(vp_run),
    .vp_rst_pulse(vp_rst_pulse), .vp_base(vp_base)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, captured at next posedge, returns at the following negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_src = s;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_src = s;
    @(negedge clk);
    bus_req = 1'b0;
    check("R6 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    check("R1 run", {28'd0, vp_run}, 32'h1);
    check("R1 pulse", {28'd0, vp_rst_pulse}, 32'h0);
    for (int i = 0; i < NV; i++) check("R1 base", vp_base[i*DW +: DW], DEF);
  endtask

  task automatic t_launch;
    wr(8'h00, 32'h6, 2'd0);
    check("R2 run", {28'd0, vp_run}, 32'h7);
    check("R4 pulse", {28'd0, vp_rst_pulse}, 32'h6);
    @(negedge clk);
    check("R4 pulse single", {28'd0, vp_rst_pulse}, 32'h0);
  endtask

  task automatic t_relaunch;
    wr(8'h00, 32'h3, 2'd1);
    check("R5 run", {28'd0, vp_run}, 32'h7);
    check("R5 pulse", {28'd0, vp_rst_pulse}, 32'h0);
  endtask

  task automatic t_halt;
    logic [31:0] d;
    wr(8'h04, 32'h5, 2'd1);
    check("R3 run", {28'd0, vp_run}, 32'h2);
    check("R3 pulse", {28'd0, vp_rst_pulse}, 32'h0);
    rd(8'h08, 2'd1, d);
    check("R6 status", d, 32'h2);
    wr(8'h00, 32'h1, 2'd1);
    check("R4 pulse vp0", {28'd0, vp_rst_pulse}, 32'h1);
    rd(8'h08, 2'd0, d);
    check("R6 status after launch", d, 32'h3);
  endtask

  task automatic t_zero_reads;
    logic [31:0] d;
    rd(8'h00, 2'd0, d); check("R7 launch reads zero", d, 32'h0);
    rd(8'h04, 2'd0, d); check("R7 halt reads zero", d, 32'h0);
    rd(8'h3C, 2'd0, d); check("R7 unmapped reads zero", d, 32'h0);
  endtask

  task automatic t_local;
    logic [31:0] d;
    wr(8'h10, 32'h1234_5678, 2'd2);
    check("R10 run kept", {28'd0, vp_run}, 32'h3);
    check("R10 no pulse", {28'd0, vp_rst_pulse}, 32'h0);
    check("R8 base out", vp_base[2*DW +: DW], 32'h1234_5000);
    rd(8'h10, 2'd2, d); check("R8 own read", d, 32'h1234_5000);
    rd(8'h10, 2'd1, d); check("R8 other own read", d, DEF);
  endtask

  task automatic t_peer;
    logic [31:0] d;
    wr(8'h0C, 32'h3, 2'd0);
    rd(8'h0C, 2'd0, d); check("R9 selector", d, 32'h3);
    rd(8'h0C, 2'd1, d); check("R9 selector private", d, 32'h0);
    wr(8'h20, 32'hABCD_E123, 2'd0);
    check("R9 peer base out", vp_base[3*DW +: DW], 32'hABCD_E000);
    check("R9 own base kept", vp_base[0*DW +: DW], DEF);
    rd(8'h20, 2'd0, d); check("R9 peer read", d, 32'hABCD_E000);
    rd(8'h20, 2'd1, d); check("R9 peer of vp1 is vp0", d, DEF);
  endtask

  task automatic t_restart;
    wr(8'h00, 32'h8, 2'd0);
    check("R4 vp3 pulse", {28'd0, vp_rst_pulse}, 32'h8);
    check("R10 base with pulse", vp_base[3*DW +: DW], 32'hABCD_E000);
    check("R2 vp3 runs", {28'd0, vp_run}, 32'hB);
  endtask

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_launch();
    t_relaunch();
    t_halt();
    t_zero_reads();
    t_local();
    t_peer();
    t_restart();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule